// File: doc/BRIEF.md
# Button-Stepped Add/Subtract Calculator Core

This block is the arithmetic and control core of a small calculator. It takes an 8-bit switch word and one clean "enter" pulse. A Moore controller moves through four phases. In the first phase the switch value appears at the output. The first press stores operand A, and the second press stores operand B. After that, each further press swaps the output between the sum and the difference of the two stored operands. The result is an 8-bit word with a negative flag and a carry flag. It is meant to feed a later decimal conversion and display stage.

The controller has four named states:

| State | Meaning | Transition on `enter` |
|---|---|---|
| `ST_IDLE` | No operand stored; output follows the switches | Load A, go to `ST_WAIT_B` |
| `ST_WAIT_B` | A stored; output follows the switches | Load B, go to `ST_SUM` |
| `ST_SUM` | Output shows A+B | Go to `ST_DIFF` |
| `ST_DIFF` | Output shows A−B | Go to `ST_SUM` |

Without `enter`, every state holds. The controller drives a 2-bit function code into a purely combinational ALU. The code values are 00 for pass A, 01 for pass B, 10 for add and 11 for subtract. It also drives an operand-load code that updates at most one register per cycle.

Top module: `calc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the core returns to `ST_IDLE` and clears both operand registers. With reset released and no press, `result` equals `switches`, and `neg_flag` and `carry_flag` are 0.
- R2: In `ST_IDLE` and `ST_WAIT_B`, `result` follows the live `switches` value combinationally through the pass-B function (code 01), and both flags are 0.
- R3: A press in `ST_IDLE` stores the `switches` value present at that clock edge as operand A.
- R4: A press in `ST_WAIT_B` stores the `switches` value at that edge as operand B. From the next cycle on, `result` shows (A+B) mod 256 (function code 10).
- R5: While the sum is shown, `carry_flag` is 1 exactly when A+B > 255, and `neg_flag` is 0.
- R6: A press in `ST_SUM` selects the difference (function code 11). `result` is then (A−B) mod 256, `neg_flag` is 1 exactly when B > A, and `carry_flag` is 0.
- R7: Each further press alternates the output between sum and difference. A press in `ST_DIFF` returns to the sum.
- R8: In the sum and difference phases, changes on `switches` have no effect on `result` or on the flags. Without a press, the phase never changes.
- R9: No clock edge changes both operand registers, except under reset.
- R10: Reset takes priority over a press that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| enter | input | 1 | Single-cycle, already debounced press pulse |
| switches | input | 8 | Operand entry word |
| result | output | 8 | ALU result |
| neg_flag | output | 1 | Difference is negative (B > A) |
| carry_flag | output | 1 | Sum exceeded 8 bits |

## Verification
Two events can land on the same clock edge: a press and a change of the switch word, or a press and a reset. The bench changes `switches` in the same cycle that it raises `enter`, then checks that the newly driven word was the one captured. It also raises `rst` together with `enter` while the sum is shown. The result then has to follow the switches with both flags clear, and a fresh capture sequence has to start from A.

// File: rtl/calc_pkg.sv
package calc_pkg;
    localparam int unsigned DATA_W = 8;

    typedef enum logic [1:0] {
        FN_PASS_A = 2'b00,
        FN_PASS_B = 2'b01,
        FN_ADD    = 2'b10,
        FN_SUB    = 2'b11
    } alu_fn_e;

    typedef enum logic [1:0] {
        RC_HOLD   = 2'b00,
        RC_LOAD_A = 2'b01,
        RC_LOAD_B = 2'b10
    } reg_ctrl_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_WAIT_B = 2'b01,
        ST_SUM    = 2'b10,
        ST_DIFF   = 2'b11
    } phase_e;
endpackage

// File: rtl/calc_ctrl.sv
module calc_ctrl
    import calc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enter,
    output alu_fn_e   fn,
    output logic      use_live,
    output reg_ctrl_e reg_ctrl
);
    phase_e state, state_nx;

    // next phase
    always_comb begin
        state_nx = state;
        if (enter) begin
            unique case (state)
                ST_IDLE:   state_nx = ST_WAIT_B;
                ST_WAIT_B: state_nx = ST_SUM;
                ST_SUM:    state_nx = ST_DIFF;
                ST_DIFF:   state_nx = ST_SUM;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // outputs: function select is Moore, load strobe qualified by enter
    always_comb begin
        fn       = FN_PASS_B;
        use_live = 1'b1;
        reg_ctrl = RC_HOLD;
        unique case (state)
            ST_IDLE: begin
                if (enter) reg_ctrl = RC_LOAD_A;
            end
            ST_WAIT_B: begin
                if (enter) reg_ctrl = RC_LOAD_B;
            end
            ST_SUM: begin
                fn       = FN_ADD;
                use_live = 1'b0;
            end
            ST_DIFF: begin
                fn       = FN_SUB;
                use_live = 1'b0;
            end
        endcase
    end

    // R4: press while waiting for B lands in the sum phase
    a_r4_waitb_to_sum: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_B && enter) |=> state == ST_SUM);
    // R6: press in the sum phase selects the difference
    a_r6_sum_to_diff: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SUM && enter) |=> state == ST_DIFF);
    // R7: press in the difference phase returns to the sum
    a_r7_diff_to_sum: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DIFF && enter) |=> state == ST_SUM);
    // R8: no press, no phase change
    a_r8_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !enter |=> $stable(state));
endmodule

// File: rtl/calc_opregs.sv
module calc_opregs
    import calc_pkg::*;
#(
    parameter int unsigned W = DATA_W
)(
    input  logic         clk,
    input  logic         rst,
    input  reg_ctrl_e    reg_ctrl,
    input  logic [W-1:0] din,
    output logic [W-1:0] op_a,
    output logic [W-1:0] op_b
);
    logic [W-1:0] op_a_nx, op_b_nx;

    // next-value logic: at most one operand takes the input word
    always_comb begin
        op_a_nx = op_a;
        op_b_nx = op_b;
        unique case (reg_ctrl)
            RC_LOAD_A: op_a_nx = din;
            RC_LOAD_B: op_b_nx = din;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_a <= '0;
            op_b <= '0;
        end else begin
            op_a <= op_a_nx;
            op_b <= op_b_nx;
        end
    end

    // R9: never both operands change on one edge outside reset
    a_r9_single_load: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> !((op_a != $past(op_a)) && (op_b != $past(op_b))));
endmodule

// File: rtl/calc_alu.sv
module calc_alu
    import calc_pkg::*;
#(
    parameter int unsigned W = DATA_W
)(
    input  alu_fn_e      fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         neg,
    output logic         carry
);
    logic [W:0] sum_ext, dif_ext;

    assign sum_ext = {1'b0, a} + {1'b0, b};
    assign dif_ext = {1'b0, a} - {1'b0, b};

    always_comb begin
        y     = a;
        neg   = 1'b0;
        carry = 1'b0;
        unique case (fn)
            FN_PASS_A: y = a;
            FN_PASS_B: y = b;
            FN_ADD: begin
                y     = sum_ext[W-1:0];
                carry = sum_ext[W];
            end
            FN_SUB: begin
                y   = dif_ext[W-1:0];
                neg = dif_ext[W];
            end
        endcase
    end
endmodule

// File: rtl/calc_core.sv
module calc_core
    import calc_pkg::*;
#(
    parameter int unsigned W = DATA_W
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         enter,
    input  logic [W-1:0] switches,
    output logic [W-1:0] result,
    output logic         neg_flag,
    output logic         carry_flag
);
    alu_fn_e      fn;
    reg_ctrl_e    reg_ctrl;
    logic         use_live;
    logic [W-1:0] op_a, op_b, alu_b;

    calc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .enter    (enter),
        .fn       (fn),
        .use_live (use_live),
        .reg_ctrl (reg_ctrl)
    );

    calc_opregs #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_ctrl (reg_ctrl),
        .din      (switches),
        .op_a     (op_a),
        .op_b     (op_b)
    );

    // the switch word reaches the output through the pass-B path
    assign alu_b = use_live ? switches : op_b;

    calc_alu #(.W(W)) u_alu (
        .fn    (fn),
        .a     (op_a),
        .b     (alu_b),
        .y     (result),
        .neg   (neg_flag),
        .carry (carry_flag)
    );

    // R5: carry only while the sum is selected
    a_r5_carry_on_add: assert property (@(posedge clk) disable iff (rst)
        carry_flag |-> fn == FN_ADD);
    // R6: negative only while the difference is selected
    a_r6_neg_on_sub: assert property (@(posedge clk) disable iff (rst)
        neg_flag |-> fn == FN_SUB);
    // R2: live phases show the switches unflagged
    a_r2_live_path: assert property (@(posedge clk) disable iff (rst)
        use_live |-> (result == switches && !neg_flag && !carry_flag));
    // R10: reset wins over a coincident press
    a_r10_reset_first: assert property (@(posedge clk)
        rst |=> (result == switches && !neg_flag && !carry_flag));
endmodule

// File: tb/calc_core_test.sv
module calc_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enter = 1'b0;
    logic [7:0] switches = 8'h00;
    logic [7:0] result;
    logic       neg_flag, carry_flag;
    int         errors = 0;
    int         checks = 0;

    always #2 clk = ~clk;

    calc_core uut (
        .clk        (clk),
        .rst        (rst),
        .enter      (enter),
        .switches   (switches),
        .result     (result),
        .neg_flag   (neg_flag),
        .carry_flag (carry_flag)
    );

    task automatic check(input string req, input logic [7:0] exp_y,
                         input logic exp_n, input logic exp_c);
        checks++;
        if (result !== exp_y || neg_flag !== exp_n || carry_flag !== exp_c) begin
            errors++;
            $display("FAIL %s: result=%0d neg=%0b carry=%0b expected result=%0d neg=%0b carry=%0b",
                     req, result, neg_flag, carry_flag, exp_y, exp_n, exp_c);
        end
    endtask

    // switches change in the same cycle as the press
    task automatic press(input logic [7:0] val);
        @(negedge clk);
        switches = val;
        enter    = 1'b1;
        @(negedge clk);
        enter    = 1'b0;
        #1;
    endtask

    task automatic do_reset(input logic [7:0] val);
        @(negedge clk);
        rst = 1'b1;
        switches = val;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic t_reset_live;
        do_reset(8'h5A);
        check("R1 reset state", 8'h5A, 1'b0, 1'b0);
        switches = 8'h13; #1;
        check("R2 idle live", 8'h13, 1'b0, 1'b0);
        switches = 8'hFF; #1;
        check("R2 idle live max", 8'hFF, 1'b0, 1'b0);
    endtask

    task automatic t_main_cycle;
        do_reset(8'h00);
        press(8'd200);
        switches = 8'h07; #1;
        check("R2 wait-B live", 8'h07, 1'b0, 1'b0);
        press(8'd100);
        check("R4 R5 R3 sum with carry", 8'd44, 1'b0, 1'b1);
        switches = 8'hAA; @(negedge clk); #1;
        check("R8 switches ignored in sum", 8'd44, 1'b0, 1'b1);
        press(8'h00);
        check("R6 diff", 8'd100, 1'b0, 1'b0);
        switches = 8'h3C; @(negedge clk); #1;
        check("R8 switches ignored in diff", 8'd100, 1'b0, 1'b0);
        press(8'h11);
        check("R7 back to sum", 8'd44, 1'b0, 1'b1);
        press(8'h22);
        check("R7 diff again", 8'd100, 1'b0, 1'b0);
    endtask

    task automatic t_negative;
        do_reset(8'h00);
        press(8'd10);
        press(8'd30);
        check("R5 sum no carry", 8'd40, 1'b0, 1'b0);
        press(8'h00);
        check("R6 negative diff", 8'hEC, 1'b1, 1'b0);
    endtask

    task automatic t_extremes;
        do_reset(8'h00);
        press(8'd255);
        press(8'd255);
        check("R5 max sum carry", 8'd254, 1'b0, 1'b1);
        press(8'h00);
        check("R6 equal operands", 8'd0, 1'b0, 1'b0);
        do_reset(8'h00);
        press(8'd0);
        press(8'd1);
        press(8'h00);
        check("R6 zero minus one", 8'hFF, 1'b1, 1'b0);
    endtask

    task automatic t_reset_with_press;
        do_reset(8'h00);
        press(8'd5);
        press(8'd6);
        check("R4 sum before reset", 8'd11, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b1; enter = 1'b1; switches = 8'h33;
        @(negedge clk);
        rst = 1'b0; enter = 1'b0;
        #1;
        check("R10 reset beats press", 8'h33, 1'b0, 1'b0);
        press(8'd1);
        check("R10 R3 restart waits for B", 8'd1, 1'b0, 1'b0);
        press(8'd2);
        check("R9 R3 fresh operands", 8'd3, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_live();
        t_main_cycle();
        t_negative();
        t_extremes();
        t_reset_with_press();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule